// File: doc/BRIEF.md
# Accumulator Variable Left Shifter

This execution unit shifts a 32-bit accumulator to the left by a variable distance. The distance comes from the low five bits of a 16-bit shift-count register, so it ranges from 0 to 31. The remaining count bits play no part. Zeros enter from the bottom. Bits pushed past the top are lost, except that the final one to leave is kept as the carry flag.

On the same edge the unit updates three status flags. Carry (C) holds the last bit shifted out, or 0 when the distance is zero. Zero (Z) and negative (N) describe the result, and they are re-evaluated even when the distance is zero. Results are registered only on a clock edge where the execute strobe is high, and otherwise hold. This operation cannot be repeated. If it executes while a repeat prefix is active, it runs once and emits a one-cycle pulse that clears the repeat counter held elsewhere.

Top module: `acc_lshift_unit`

## Requirements
- R1: The shift distance is `cnt_i[4:0]`. Bits `cnt_i[15:5]` have no effect on any output.
- R2: On an executing edge, `acc_o` becomes `acc_i` shifted left by the distance, with zeros filling the vacated low bits and the bits above bit 31 discarded.
- R3: For a nonzero distance k, `c_o` becomes `acc_i[32-k]`, the last bit shifted out.
- R4: For a distance of zero, `c_o` becomes 0 and `acc_o` becomes `acc_i` unchanged.
- R5: On an executing edge, `z_o` becomes 1 exactly when the 32-bit result is zero, including for a distance of zero.
- R6: On an executing edge, `n_o` becomes bit 31 of the result, including for a distance of zero.
- R7: On an edge where `exec_i` is low, `acc_o`, `c_o`, `z_o` and `n_o` keep their values.
- R8: `rpt_clr_o` is high for exactly the one cycle after an edge where `exec_i` and `rpt_active_i` are both high, and low otherwise.
- R9: A synchronous active-high `rst` sets `acc_o`, `c_o`, `z_o`, `n_o` and `rpt_clr_o` to 0.
- R10: The result and flags of an execute appear on the outputs one clock after the executing edge, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe for the shift |
| rpt_active_i | input | 1 | A repeat prefix is pending |
| acc_i | input | 32 | Accumulator operand |
| cnt_i | input | 16 | Shift-count register; only bits 4:0 are used |
| acc_o | output | 32 | Registered shifted accumulator |
| c_o | output | 1 | Registered carry flag |
| z_o | output | 1 | Registered zero flag |
| n_o | output | 1 | Registered negative flag |
| rpt_clr_o | output | 1 | One-cycle pulse that clears the repeat counter |

## Verification
A single-bit-at-each-end operand is shifted by every distance from 0 to 31. This separates the carry taken from bit 32-k from a neighbouring bit, and it exposes a wrong stage in the shifter. Pseudo-random operands with count values that have their upper bits set show whether only the five low bits steer the shift. Chosen operands whose surviving bits are all shifted away, and a distance of zero applied to negative and to zero operands, show that Z and N follow the result while C is cleared. Cycles with the strobe low but changing operands, and strobes with and without the repeat prefix, distinguish holding from loading and a correct clear pulse from a stuck one.

// File: rtl/acc_lshift_pkg.sv
package acc_lshift_pkg;
    parameter int ACC_W = 32;
    parameter int CNT_W = 16;
    localparam int AMT_W = $clog2(ACC_W);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             c;
        logic             z;
        logic             n;
        logic             rpt_clr;
    } lsh_state_t;
endpackage

// File: rtl/acc_lshift_barrel.sv
module acc_lshift_barrel #(
    parameter int W     = 32,
    parameter int AMT_W = $clog2(W)
) (
    input  logic [W-1:0]     operand_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [W-1:0]     result_o,
    output logic             carry_o
);
    localparam int STAGES = AMT_W;
    localparam int XW     = W + 1;

    // One guard bit above the word catches the last bit to leave.
    logic [XW-1:0] stage_w [STAGES+1];

    assign stage_w[0] = {1'b0, operand_i};

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            localparam int DIST = 1 << s;
            always_comb begin
                if (amt_i[s]) begin
                    stage_w[s+1] = stage_w[s] << DIST;
                end else begin
                    stage_w[s+1] = stage_w[s];
                end
            end
        end
    endgenerate

    assign result_o = stage_w[STAGES][W-1:0];
    assign carry_o  = stage_w[STAGES][W];

    // R4: a zero distance leaves the word alone and clears carry
    always_comb begin
        if (amt_i == '0) begin
            p_zero_dist_r4: assert (carry_o == 1'b0 && result_o == operand_i);
        end
    end
endmodule

// File: rtl/acc_lshift_flags.sv
module acc_lshift_flags #(
    parameter int W = 32
) (
    input  logic [W-1:0] result_i,
    output logic         zero_o,
    output logic         neg_o
);
    assign zero_o = (result_i == '0);
    assign neg_o  = result_i[W-1];
endmodule

// File: rtl/acc_lshift_unit.sv
module acc_lshift_unit
    import acc_lshift_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             exec_i,
    input  logic             rpt_active_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             c_o,
    output logic             z_o,
    output logic             n_o,
    output logic             rpt_clr_o
);
    logic [AMT_W-1:0] amt_w;
    logic [ACC_W-1:0] shifted_w;
    logic             carry_w;
    logic             zero_w;
    logic             neg_w;
    lsh_state_t       state_d;
    lsh_state_t       state_q;

    // Only the low count bits select a distance.
    assign amt_w = cnt_i[AMT_W-1:0];

    acc_lshift_barrel #(
        .W     (ACC_W),
        .AMT_W (AMT_W)
    ) i_barrel (
        .operand_i (acc_i),
        .amt_i     (amt_w),
        .result_o  (shifted_w),
        .carry_o   (carry_w)
    );

    acc_lshift_flags #(
        .W (ACC_W)
    ) i_flags (
        .result_i (shifted_w),
        .zero_o   (zero_w),
        .neg_o    (neg_w)
    );

    always_comb begin
        state_d         = state_q;
        state_d.rpt_clr = exec_i & rpt_active_i;
        if (exec_i) begin
            state_d.acc = shifted_w;
            state_d.c   = carry_w;
            state_d.z   = zero_w;
            state_d.n   = neg_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_o     = state_q.acc;
    assign c_o       = state_q.c;
    assign z_o       = state_q.z;
    assign n_o       = state_q.n;
    assign rpt_clr_o = state_q.rpt_clr;

    // R7: no strobe, no change
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !exec_i |=> ($stable(acc_o) && $stable(c_o) && $stable(z_o) && $stable(n_o)));

    // R5: zero flag agrees with the loaded result
    p_zero_flag_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(exec_i) && !$past(rst)) |-> (z_o == (acc_o == '0)));

    // R6: negative flag agrees with the loaded result
    p_neg_flag_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(exec_i) && !$past(rst)) |-> (n_o == acc_o[ACC_W-1]));

    // R8: a clear pulse only follows an execute under a repeat prefix
    p_rpt_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rpt_clr_o |-> ($past(exec_i) && $past(rpt_active_i)));

    // R1/R4: a zero low count field always yields a clear carry
    p_mask_carry_r1: assert property (@(posedge clk) disable iff (rst)
        (exec_i && cnt_i[AMT_W-1:0] == '0) |=> !c_o);
endmodule

// File: tb/test_acc_lshift_unit.sv
module test_acc_lshift_unit;
    localparam time PERIOD = 4ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        exec_i;
    logic        rpt_active_i;
    logic [31:0] acc_i;
    logic [15:0] cnt_i;
    logic [31:0] acc_o;
    logic        c_o, z_o, n_o, rpt_clr_o;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [31:0] m_acc;
    logic        m_c, m_z, m_n, m_rc;
    logic [31:0] lcg = 32'h1234_5678;

    always #(PERIOD/2) clk = ~clk;

    acc_lshift_unit i_acc_lshift_unit (
        .clk, .rst, .exec_i, .rpt_active_i, .acc_i, .cnt_i,
        .acc_o, .c_o, .z_o, .n_o, .rpt_clr_o
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "acc", acc_o, m_acc);
        check(tag, "c", {31'd0, c_o}, {31'd0, m_c});
        check(tag, "z", {31'd0, z_o}, {31'd0, m_z});
        check(tag, "n", {31'd0, n_o}, {31'd0, m_n});
        check(tag, "rpt_clr", {31'd0, rpt_clr_o}, {31'd0, m_rc});
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(input string tag, input logic r, input logic ex,
                        input logic rp, input logic [31:0] a, input logic [15:0] cn);
        longint unsigned wide;
        int k;
        rst = r; exec_i = ex; rpt_active_i = rp; acc_i = a; cnt_i = cn;
        @(posedge clk);
        k = int'(cn % 16'd32);
        wide = longint'(a) << k;
        if (r) begin
            m_acc = '0; m_c = 0; m_z = 0; m_n = 0; m_rc = 0;
        end else begin
            m_rc = ex && rp;
            if (ex) begin
                m_acc = wide[31:0];
                m_c   = (k == 0) ? 1'b0 : wide[32];
                m_z   = (m_acc == 0);
                m_n   = m_acc[31];
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; exec_i = 0; rpt_active_i = 0; acc_i = 32'hFFFF_FFFF; cnt_i = 16'd5;
        @(negedge clk);
        step("R9 reset", 1, 1, 1, 32'hFFFF_FFFF, 16'd5);
        step("R9 reset", 1, 0, 0, 0, 0);

        // R2 R3 R10: every distance on a two-ended pattern
        for (int k = 0; k < 32; k++) begin
            step("R2 R3 R10 sweep", 0, 1, 0, 32'h8000_0001, 16'(k));
        end
        for (int k = 1; k < 32; k++) begin
            step("R3 carry sweep", 0, 1, 0, 32'h0000_0001 << (32 - k), 16'(k));
        end

        // R1: upper count bits set
        for (int i = 0; i < 40; i++) begin
            lcg = next_rand(lcg);
            step("R1 R2 masked count", 0, 1, 0, lcg, {lcg[26:16], lcg[4:0]} | 16'hFFE0);
        end
        step("R1 upper bits only", 0, 1, 0, 32'hC000_0001, 16'hFFE0);

        // R4: zero distance
        step("R4 zero distance", 0, 1, 0, 32'hFFFF_FFFF, 16'd0);
        step("R4 R6 zero distance neg", 0, 1, 0, 32'h8000_0000, 16'h0020);
        step("R4 R5 zero distance zero", 0, 1, 0, 32'h0000_0000, 16'd0);

        // R5: everything shifted away
        step("R5 shifted to zero", 0, 1, 0, 32'h0001_0000, 16'd16);
        step("R5 R6 one survives", 0, 1, 0, 32'h0001_0000, 16'd15);
        step("R6 positive", 0, 1, 0, 32'h4000_0000, 16'd0);

        // R7: strobe low with changing operands
        step("R7 hold", 0, 0, 0, 32'h1234_5678, 16'd3);
        step("R7 hold", 0, 0, 1, 32'h0000_0000, 16'd0);
        step("R7 hold", 0, 0, 0, 32'hFFFF_FFFF, 16'd31);

        // R8: repeat prefix
        step("R8 pulse", 0, 1, 1, 32'h0000_00F0, 16'd4);
        step("R8 pulse ends", 0, 1, 0, 32'h0000_00F0, 16'd4);
        step("R8 no exec", 0, 0, 1, 32'h0000_00F0, 16'd4);
        step("R8 pulse again", 0, 1, 1, 32'h8000_0000, 16'd1);

        // R9: reset after activity
        step("R9 reset mid", 1, 0, 0, 0, 0);
        step("R9 after reset", 0, 0, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule